// File: doc/BRIEF.md
# Reset Cause Flag Register

This block is a small memory-mapped status register that remembers why the chip last came out of reset. Five reset sources each drive a one-cycle request pulse into it: power-on, the external reset pin, the supply brown-out detector, the watchdog, and the debug port. Each pulse latches a sticky flag. The flag stays set until software clears it or until a power-on event wipes it.

Software reads all five flags in one access through a simple register port. The port has an address, a write enable and write data. Read data is combinational and has no side effects. Early in boot, software reads the register to find out which source caused the reset. It then writes zeros to clear the flags it has handled.

Clearing is done by writing zero to a bit. Writing one leaves the bit alone. A power-on event sets the power-on flag and clears the other four. The power-on flag itself is never cleared by any event. Only a software write of zero clears it.

Top module: `rst_cause_flags`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, every flag reads as 0.
- R2: Flag positions are fixed: bit 0 is power-on, bit 1 is external pin, bit 2 is brown-out, bit 3 is watchdog and bit 4 is debug port. A one-cycle pulse on a source's input makes that flag read 1 from the next clock edge onward.
- R3: A write to the register address with bit k of the data at 0 clears flag k at the next clock edge.
- R4: A write to the register address with bit k of the data at 1 leaves flag k unchanged.
- R5: A power-on pulse sets flag 0 and clears flags 4:1 at the same edge. This holds even when other source inputs or a write are active in that cycle.
- R6: Flag 0 is never cleared by any source pulse. Only a register write of 0 to bit 0 clears it.
- R7: If a source pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: A read at the register address returns the flags in bits 4:0 and zeros in bits 7:5. Reading changes no flag.
- R9: A write to any other address changes no flag. A read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low storage initialisation, clears all flags |
| porEvt | input | 1 | Power-on reset event pulse |
| extEvt | input | 1 | External pin reset event pulse |
| borEvt | input | 1 | Brown-out reset event pulse |
| wdtEvt | input | 1 | Watchdog reset event pulse |
| dbgEvt | input | 1 | Debug-port reset request pulse |
| busAddr | input | ADDR_W | Register address for read and write |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data, a 0 bit clears the matching flag |
| busRdData | output | DATA_W | Combinational read data |

## Verification
The bench builds the block with a 4-bit address, 8-bit data and the register placed at address 0xA rather than the default. This makes the address decode visible: writes and reads at a neighbouring address must leave the flags untouched and read as zero. With 8-bit data, bits 7:5 are live port bits, so the zero-fill of the unused upper bits is checked on every read. The vector walk also drives combined events and writes in one cycle, which reaches the set-over-clear and power-on-override orderings.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

  localparam int FLAG_W = 5;

  // Flag positions; software decodes these, so they are fixed.
  localparam int IDX_POR = 0;
  localparam int IDX_EXT = 1;
  localparam int IDX_BOR = 2;
  localparam int IDX_WDT = 3;
  localparam int IDX_DBG = 4;

  typedef struct packed {
    logic              por;   // power-on event this cycle
    logic [FLAG_W-1:0] set;   // per-flag set request
    logic [FLAG_W-1:0] clr;   // per-flag software clear
  } rcf_strobe_t;

endpackage

// File: rtl/rcf_ctrl.sv
module rcf_ctrl
  import rcf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] evtVec,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic              regHit,
  output rcf_strobe_t       strb
);

  logic wrHit;

  always_comb begin
    regHit   = (busAddr == REG_ADDR);
    wrHit    = busWrEn && regHit;
    strb.por = evtVec[IDX_POR];
    strb.set = evtVec;
    strb.clr = wrHit ? ~busWrData[FLAG_W-1:0] : '0;
  end

  // A write aimed at another address must not produce any clear.
  assert_foreign_write_inert_R9 : assert property (
    @(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != REG_ADDR) |-> (strb.clr == '0)
  );

  // Writing all ones to the register requests no clear at all.
  assert_ones_write_no_clear_R4 : assert property (
    @(posedge clk) disable iff (!rstN)
    (busWrEn && regHit && (&busWrData[FLAG_W-1:0])) |-> (strb.clr == '0)
  );

endmodule

// File: rtl/rcf_flags.sv
module rcf_flags
  import rcf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rcf_strobe_t       strb,
  output logic [FLAG_W-1:0] flagQ
);

  logic [FLAG_W-1:0] flagD;

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    if (k == IDX_POR) begin : g_por
      // Power-on flag: only software clears it, its own event sets it.
      always_comb flagD[k] = strb.set[k] | (flagQ[k] & ~strb.clr[k]);
    end else begin : g_other
      // Other flags: wiped by power-on, otherwise set wins over clear.
      always_comb flagD[k] = strb.por ? 1'b0
                                      : (strb.set[k] | (flagQ[k] & ~strb.clr[k]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagD;
  end

  assert_por_override_R5 : assert property (
    @(posedge clk) disable iff (!rstN)
    strb.por |=> (flagQ == FLAG_W'(1))
  );

  assert_event_sets_R2 : assert property (
    @(posedge clk) disable iff (!rstN)
    (!strb.por && (|strb.set)) |=> ((flagQ & $past(strb.set)) == $past(strb.set))
  );

  assert_set_beats_clear_R7 : assert property (
    @(posedge clk) disable iff (!rstN)
    (!strb.por && (|(strb.set & strb.clr))) |=>
      ((flagQ & $past(strb.set & strb.clr)) == $past(strb.set & strb.clr))
  );

  assert_por_flag_sticky_R6 : assert property (
    @(posedge clk) disable iff (!rstN)
    (!strb.clr[IDX_POR] && flagQ[IDX_POR]) |=> flagQ[IDX_POR]
  );

  assert_no_clear_no_drop_R4 : assert property (
    @(posedge clk) disable iff (!rstN)
    (!strb.por && strb.clr == '0) |=> ((flagQ & $past(flagQ)) == $past(flagQ))
  );

endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rcf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porEvt,
  input  logic              extEvt,
  input  logic              borEvt,
  input  logic              wdtEvt,
  input  logic              dbgEvt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);

  localparam int PAD_W = DATA_W - FLAG_W;

  logic [FLAG_W-1:0] evtVec;
  logic [FLAG_W-1:0] flagQ;
  logic              regHit;
  rcf_strobe_t       strb;

  always_comb begin
    evtVec          = '0;
    evtVec[IDX_POR] = porEvt;
    evtVec[IDX_EXT] = extEvt;
    evtVec[IDX_BOR] = borEvt;
    evtVec[IDX_WDT] = wdtEvt;
    evtVec[IDX_DBG] = dbgEvt;
  end

  rcf_ctrl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evtVec   (evtVec),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .regHit   (regHit),
    .strb     (strb)
  );

  rcf_flags i_flags (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .flagQ(flagQ)
  );

  if (PAD_W > 0) begin : g_pad
    assign busRdData = regHit ? {{PAD_W{1'b0}}, flagQ} : '0;
  end else begin : g_nopad
    assign busRdData = regHit ? flagQ[DATA_W-1:0] : '0;
  end

  assert_upper_bits_zero_R8 : assert property (
    @(posedge clk) disable iff (!rstN)
    (busRdData >> FLAG_W) == '0
  );

  assert_other_addr_reads_zero_R9 : assert property (
    @(posedge clk) disable iff (!rstN)
    (busAddr != REG_ADDR) |-> (busRdData == '0)
  );

endmodule

// File: tb/test_rst_cause_flags.sv
module test_rst_cause_flags;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] REG_A = 4'hA;
  localparam logic [ADDR_W-1:0] OTH_A = 4'hB;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              porEvt = 1'b0, extEvt = 1'b0, borEvt = 1'b0, wdtEvt = 1'b0, dbgEvt = 1'b0;
  logic [ADDR_W-1:0] busAddr = REG_A;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rst_cause_flags #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_A)
  ) i_rst_cause_flags (
    .clk(clk), .rstN(rstN),
    .porEvt(porEvt), .extEvt(extEvt), .borEvt(borEvt), .wdtEvt(wdtEvt), .dbgEvt(dbgEvt),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData)
  );

  // Vector: {events[4:0] (dbg,wdt,bor,ext,por), wrEn, addr[3:0], wrData[7:0], expected[7:0]}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {5'b00001, 1'b0, 4'hA, 8'h00, 8'h01},  // R2 power-on flag
    {5'b00010, 1'b0, 4'hA, 8'h00, 8'h03},  // R2 external
    {5'b00100, 1'b0, 4'hA, 8'h00, 8'h07},  // R2 brown-out
    {5'b01000, 1'b0, 4'hA, 8'h00, 8'h0F},  // R2 watchdog
    {5'b10000, 1'b0, 4'hA, 8'h00, 8'h1F},  // R2 debug
    {5'b00000, 1'b1, 4'hA, 8'hFF, 8'h1F},  // R4 ones keep
    {5'b00000, 1'b1, 4'hA, 8'hFD, 8'h1D},  // R3 clear bit 1
    {5'b00000, 1'b1, 4'hB, 8'h00, 8'h1D},  // R9 other address
    {5'b11111, 1'b1, 4'hA, 8'h00, 8'h01},  // R5 power-on overrides all
    {5'b01010, 1'b0, 4'hA, 8'h00, 8'h0B},  // R2 two sources
    {5'b00000, 1'b1, 4'hA, 8'hF6, 8'h02},  // R3 R6 write clears power-on and watchdog
    {5'b00100, 1'b1, 4'hA, 8'h00, 8'h04},  // R7 set beats clear
    {5'b11110, 1'b0, 4'hA, 8'h00, 8'h1E},  // R6 other events leave bit 0 clear
    {5'b00000, 1'b1, 4'hA, 8'hE0, 8'h00}   // R3 clear all
  };

  task automatic check(input string req, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    {dbgEvt, wdtEvt, borEvt, extEvt, porEvt} = '0;
    busWrEn = 1'b0; busWrData = '0; busAddr = REG_A;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    idle();
    repeat (3) @(negedge clk);
    check("R1 during reset", busRdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", busRdData, 8'h00);

    for (int i = 0; i < NV; i++) begin
      {dbgEvt, wdtEvt, borEvt, extEvt, porEvt} = VEC[i][25:21];
      busWrEn   = VEC[i][20];
      busAddr   = VEC[i][19:16];
      busWrData = VEC[i][15:8];
      @(negedge clk);
      idle();
      #1;
      check($sformatf("vector %0d", i), busRdData, VEC[i][7:0]);
    end

    // R8: repeated reads change nothing
    @(negedge clk); {wdtEvt, extEvt} = 2'b11;
    @(negedge clk); idle(); #1;
    check("R8 read value", busRdData, 8'h0A);
    repeat (3) @(negedge clk);
    check("R8 read has no side effect", busRdData, 8'h0A);

    // R9: read at another address returns zero, flags intact
    busAddr = OTH_A; #1;
    check("R9 foreign read zero", busRdData, 8'h00);
    busAddr = REG_A; #1;
    check("R9 flags intact", busRdData, 8'h0A);

    // R5: power-on with simultaneous write of ones still clears 4:1
    porEvt = 1'b1; dbgEvt = 1'b1; busWrEn = 1'b1; busWrData = 8'hFF;
    @(negedge clk); idle(); #1;
    check("R5 por with write", busRdData, 8'h01);

    // R6: bit 0 survives a second power-on and a write of ones
    porEvt = 1'b1;
    @(negedge clk); idle(); busWrEn = 1'b1; busWrData = 8'hFF;
    @(negedge clk); idle(); #1;
    check("R6 por flag sticky", busRdData, 8'h01);

    // R1: mid-run reset clears flags
    borEvt = 1'b1;
    @(negedge clk); idle();
    rstN = 1'b0; #1;
    check("R1 mid-run reset", busRdData, 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 after second reset", busRdData, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule